// File: doc/BRIEF.md
# Translation Context and Access Permission Checker

This block sits after the page-table walker in an address translation path. For each access request it takes the processor privilege state (hypervisor mode, problem state) and the two most significant bits of the effective address, the quadrant, and from them selects the partition and process identifiers that qualify the translation. It then judges the requested read, write or fetch against the rights encoded in the leaf entry that the walker found. In supervisor state it also applies the rights in an authority mask register.

Each request produces one registered result one cycle later. The result is either a grant carrying the granted rights and the selected context, or a classified fault. A fault is a segment or storage fault, on the instruction or the data side, and carries a cause word and the faulting address. The block also holds three architectural fault registers that it updates as a side effect of faults: the data fault address, the data fault status and the error code. Fetching the entry itself is done elsewhere.

Top module: `xlate_auth_chk`

## Requirements
- R1: For every cycle with `req_valid_i` high, `valid_o` is high for exactly one cycle on the next cycle, with exactly one of `grant_o` and `fault_o` set. With `valid_o` low, both flags are low.
- R2: With `hv_mode_i`=1 the quadrant (`ea_i[EA_W-1:EA_W-2]`) selects the pair (partition, process) as follows: quadrant 0 gives (0, `pid_reg_i`), quadrant 1 gives (`lpid_reg_i`, `pid_reg_i`), quadrant 2 gives (`lpid_reg_i`, 0) and quadrant 3 gives (0, 0). The pair is reported on `lpid_o`/`pid_o`.
- R3: With `hv_mode_i`=0, quadrant 0 gives (`lpid_reg_i`, `pid_reg_i`) and quadrant 3 gives (`lpid_reg_i`, 0).
- R4: With `hv_mode_i`=0, quadrants 1 and 2 fault as segment faults whatever the entry holds. The `exc_o` code is 0 for a fetch (`access_i`=2) and 1 for a read (0) or write (1). `cause_o`, `rights_o`, `lpid_o` and `pid_o` are zero. A data segment fault loads `ea_i` into `dar_o`.
- R5: A fetch from an entry whose attribute field (`entry_i[5:4]`) is 2'b11 (non-idempotent I/O) is an instruction storage fault (`exc_o`=2) with only the guarded cause bit (`cause_o[0]`) set. This holds even when the entry grants execute.
- R6: Rights bits are read (bit 0), write (bit 1) and execute (bit 2), both in `entry_i[2:0]` and in `amr_rights_i`. The privileged bit is `entry_i[3]`. When it is set and `problem_i`=1, the granted rights are none.
- R7: When exactly one of `problem_i` and the privileged bit is set, the granted rights are `entry_i[2:0]` and the mask is not applied.
- R8: In supervisor state (`problem_i`=0) on a non-privileged entry, the granted rights are `entry_i[2:0] & amr_rights_i`.
- R9: If the requested right is absent from the granted rights, the result is a storage fault with the protection cause bit (`cause_o[1]`) set. `exc_o` is 2 for a fetch and 3 for data. Otherwise the result is a grant with `rights_o` equal to the granted rights.
- R10: A data storage fault on a write also sets the store bit (`cause_o[2]`). Every data storage fault loads the cause into `dsisr_o` and the address into `dar_o`. Segment faults and instruction faults leave `dsisr_o` unchanged.
- R11: An instruction storage fault loads its cause into `err_code_o`. Every other fault clears `err_code_o`. Grants leave `dar_o`, `dsisr_o` and `err_code_o` unchanged.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| access_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| ea_i | input | EA_W | Effective address; top two bits are the quadrant |
| hv_mode_i | input | 1 | Processor in hypervisor mode |
| problem_i | input | 1 | Processor in problem (user) state |
| lpid_reg_i | input | LPID_W | Partition identifier register |
| pid_reg_i | input | PID_W | Process identifier register |
| amr_rights_i | input | 3 | Authority mask rights (read, write, execute) |
| entry_i | input | 6 | Leaf entry: rights [2:0], privileged [3], attribute [5:4] |
| valid_o | output | 1 | Result strobe |
| grant_o | output | 1 | Access allowed |
| fault_o | output | 1 | Access faulted |
| rights_o | output | 3 | Granted rights on a grant, else zero |
| lpid_o | output | LPID_W | Selected partition identifier |
| pid_o | output | PID_W | Selected process identifier |
| exc_o | output | 2 | Fault class: 0 inst segment, 1 data segment, 2 inst storage, 3 data storage |
| cause_o | output | CAUSE_W | Fault cause: guarded [0], protection [1], store [2] |
| fault_addr_o | output | EA_W | Faulting effective address |
| dar_o | output | EA_W | Data fault address register |
| dsisr_o | output | CAUSE_W | Data fault status register |
| err_code_o | output | CAUSE_W | Error code register |

## Verification
The hardest situation to reach is where the checks overlap. An entry is marked non-idempotent I/O and grants execute, so only the ordering of the guard check decides the outcome. An illegal guest quadrant arrives with an entry that would itself fault, so the segment check must win. The stimulus builds such entries deliberately and interleaves faults of every class back to back. Each one must then leave the three fault registers exactly as the previous fault of the right class set them. The scoreboard carries the expected register contents from item to item rather than resetting them per test.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam logic [1:0] EXC_ISEG = 2'd0;
  localparam logic [1:0] EXC_DSEG = 2'd1;
  localparam logic [1:0] EXC_ISTO = 2'd2;
  localparam logic [1:0] EXC_DSTO = 2'd3;

  localparam int RB_RD = 0;
  localparam int RB_WR = 1;
  localparam int RB_EX = 2;

  localparam int ENT_W    = 6;
  localparam int ENT_PRIV = 3;
  localparam int ENT_ATT  = 4;
  localparam logic [1:0] ATT_NIO = 2'b11;

  localparam int CB_GUARD = 0;
  localparam int CB_PROT  = 1;
  localparam int CB_STORE = 2;
endpackage

// File: rtl/ctx_sel.sv
module ctx_sel #(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic              hv_i,
  input  logic [1:0]        quad_i,
  input  logic [LPID_W-1:0] lpid_reg_i,
  input  logic [PID_W-1:0]  pid_reg_i,
  output logic [LPID_W-1:0] lpid_o,
  output logic [PID_W-1:0]  pid_o,
  output logic              legal_o
);
  always_comb begin
    lpid_o  = '0;
    pid_o   = '0;
    legal_o = 1'b1;
    if (hv_i) begin
      unique case (quad_i)
        2'd0: pid_o = pid_reg_i;
        2'd1: begin lpid_o = lpid_reg_i; pid_o = pid_reg_i; end
        2'd2: lpid_o = lpid_reg_i;
        default: ;
      endcase
    end else begin
      unique case (quad_i)
        2'd0: begin lpid_o = lpid_reg_i; pid_o = pid_reg_i; end
        2'd3: lpid_o = lpid_reg_i;
        default: legal_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/perm_eval.sv
module perm_eval
  import xlate_pkg::*;
#(
  parameter int CAUSE_W = 8
) (
  input  logic [1:0]       acc_i,
  input  logic             problem_i,
  input  logic [ENT_W-1:0] entry_i,
  input  logic [2:0]       amr_i,
  output logic [2:0]       rights_o,
  output logic             deny_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic       priv;
  logic       io_fetch;
  logic [2:0] need;

  assign priv     = entry_i[ENT_PRIV];
  assign io_fetch = (acc_i == ACC_EX) && (entry_i[ENT_ATT+:2] == ATT_NIO);

  always_comb begin
    need = '0;
    unique case (acc_i)
      ACC_RD:  need[RB_RD] = 1'b1;
      ACC_WR:  need[RB_WR] = 1'b1;
      ACC_EX:  need[RB_EX] = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    if (priv && problem_i)      rights_o = 3'b000;
    else if (priv || problem_i) rights_o = entry_i[2:0];
    else                        rights_o = entry_i[2:0] & amr_i;
  end

  // guard check precedes the permission check
  always_comb begin
    cause_o = '0;
    deny_o  = 1'b0;
    if (io_fetch) begin
      cause_o[CB_GUARD] = 1'b1;
      deny_o = 1'b1;
    end else if ((need & ~rights_o) != 3'b000) begin
      cause_o[CB_PROT] = 1'b1;
      deny_o = 1'b1;
    end
  end
endmodule

// File: rtl/fault_report.sv
module fault_report
  import xlate_pkg::*;
#(
  parameter int EA_W    = 64,
  parameter int LPID_W  = 12,
  parameter int PID_W   = 20,
  parameter int CAUSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         acc_i,
  input  logic [EA_W-1:0]    ea_i,
  input  logic               legal_i,
  input  logic               deny_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [2:0]         rights_i,
  input  logic [LPID_W-1:0]  lpid_i,
  input  logic [PID_W-1:0]   pid_i,
  output logic               valid_o,
  output logic               grant_o,
  output logic               fault_o,
  output logic [2:0]         rights_o,
  output logic [LPID_W-1:0]  lpid_o,
  output logic [PID_W-1:0]   pid_o,
  output logic [1:0]         exc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [EA_W-1:0]    fault_addr_o,
  output logic [EA_W-1:0]    dar_o,
  output logic [CAUSE_W-1:0] dsisr_o,
  output logic [CAUSE_W-1:0] err_code_o
);
  logic               is_fetch;
  logic [CAUSE_W-1:0] sto_cause;

  assign is_fetch = (acc_i == ACC_EX);

  always_comb begin
    sto_cause = cause_i;
    if (acc_i == ACC_WR) sto_cause[CB_STORE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      grant_o      <= 1'b0;
      fault_o      <= 1'b0;
      rights_o     <= '0;
      lpid_o       <= '0;
      pid_o        <= '0;
      exc_o        <= '0;
      cause_o      <= '0;
      fault_addr_o <= '0;
      dar_o        <= '0;
      dsisr_o      <= '0;
      err_code_o   <= '0;
    end else begin
      valid_o <= req_i;
      if (!req_i) begin
        grant_o <= 1'b0;
        fault_o <= 1'b0;
      end else if (!legal_i) begin
        grant_o      <= 1'b0;
        fault_o      <= 1'b1;
        rights_o     <= '0;
        lpid_o       <= '0;
        pid_o        <= '0;
        exc_o        <= is_fetch ? EXC_ISEG : EXC_DSEG;
        cause_o      <= '0;
        fault_addr_o <= ea_i;
        err_code_o   <= '0;
        if (!is_fetch) dar_o <= ea_i;
      end else if (deny_i) begin
        grant_o      <= 1'b0;
        fault_o      <= 1'b1;
        rights_o     <= '0;
        lpid_o       <= lpid_i;
        pid_o        <= pid_i;
        fault_addr_o <= ea_i;
        if (is_fetch) begin
          exc_o      <= EXC_ISTO;
          cause_o    <= cause_i;
          err_code_o <= cause_i;
        end else begin
          exc_o      <= EXC_DSTO;
          cause_o    <= sto_cause;
          dsisr_o    <= sto_cause;
          dar_o      <= ea_i;
          err_code_o <= '0;
        end
      end else begin
        grant_o      <= 1'b1;
        fault_o      <= 1'b0;
        rights_o     <= rights_i;
        lpid_o       <= lpid_i;
        pid_o        <= pid_i;
        exc_o        <= '0;
        cause_o      <= '0;
        fault_addr_o <= '0;
      end
    end
  end

  assert_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (grant_o ^ fault_o));
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!grant_o && !fault_o));
  assert_seg_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o && !exc_o[1]) |-> (cause_o == '0 && rights_o == 3'b000));
  assert_store_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o && exc_o == EXC_DSTO) |->
      (cause_o[CB_STORE] == ($past(acc_i) == ACC_WR)));
  assert_dar_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o && exc_o[0]) |-> (dar_o == fault_addr_o));
  assert_dsisr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !(fault_o && exc_o == EXC_DSTO)) |-> $stable(dsisr_o));
  assert_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o && exc_o == EXC_ISTO) |-> (err_code_o == cause_o));
  assert_wr_right_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && grant_o && $past(acc_i) == ACC_WR) |-> rights_o[RB_WR]);
endmodule

// File: rtl/xlate_auth_chk.sv
module xlate_auth_chk
  import xlate_pkg::*;
#(
  parameter int EA_W    = 64,
  parameter int LPID_W  = 12,
  parameter int PID_W   = 20,
  parameter int CAUSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         access_i,
  input  logic [EA_W-1:0]    ea_i,
  input  logic               hv_mode_i,
  input  logic               problem_i,
  input  logic [LPID_W-1:0]  lpid_reg_i,
  input  logic [PID_W-1:0]   pid_reg_i,
  input  logic [2:0]         amr_rights_i,
  input  logic [5:0]         entry_i,
  output logic               valid_o,
  output logic               grant_o,
  output logic               fault_o,
  output logic [2:0]         rights_o,
  output logic [LPID_W-1:0]  lpid_o,
  output logic [PID_W-1:0]   pid_o,
  output logic [1:0]         exc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [EA_W-1:0]    fault_addr_o,
  output logic [EA_W-1:0]    dar_o,
  output logic [CAUSE_W-1:0] dsisr_o,
  output logic [CAUSE_W-1:0] err_code_o
);
  localparam int QUAD_LSB = EA_W - 2;

  logic [LPID_W-1:0]  ctx_lpid;
  logic [PID_W-1:0]   ctx_pid;
  logic               ctx_legal;
  logic [2:0]         perm_rights;
  logic               perm_deny;
  logic [CAUSE_W-1:0] perm_cause;

  ctx_sel #(.LPID_W(LPID_W), .PID_W(PID_W)) u_ctx (
    .hv_i       (hv_mode_i),
    .quad_i     (ea_i[QUAD_LSB+:2]),
    .lpid_reg_i (lpid_reg_i),
    .pid_reg_i  (pid_reg_i),
    .lpid_o     (ctx_lpid),
    .pid_o      (ctx_pid),
    .legal_o    (ctx_legal)
  );

  perm_eval #(.CAUSE_W(CAUSE_W)) u_perm (
    .acc_i     (access_i),
    .problem_i (problem_i),
    .entry_i   (entry_i),
    .amr_i     (amr_rights_i),
    .rights_o  (perm_rights),
    .deny_o    (perm_deny),
    .cause_o   (perm_cause)
  );

  fault_report #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .CAUSE_W(CAUSE_W)) u_rep (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_valid_i),
    .acc_i        (access_i),
    .ea_i         (ea_i),
    .legal_i      (ctx_legal),
    .deny_i       (perm_deny),
    .cause_i      (perm_cause),
    .rights_i     (perm_rights),
    .lpid_i       (ctx_lpid),
    .pid_i        (ctx_pid),
    .valid_o      (valid_o),
    .grant_o      (grant_o),
    .fault_o      (fault_o),
    .rights_o     (rights_o),
    .lpid_o       (lpid_o),
    .pid_o        (pid_o),
    .exc_o        (exc_o),
    .cause_o      (cause_o),
    .fault_addr_o (fault_addr_o),
    .dar_o        (dar_o),
    .dsisr_o      (dsisr_o),
    .err_code_o   (err_code_o)
  );

  assert_legal_access_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (access_i != 2'd3));
  assert_guest_ctx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hv_mode_i && ctx_legal) |=> (lpid_o == $past(lpid_reg_i)));
endmodule

// File: tb/sim_xlate_auth_chk.sv
module sim_xlate_auth_chk;
  localparam int EA_W = 64;
  localparam int LW   = 12;
  localparam int PW   = 20;
  localparam int CW   = 8;

  typedef struct packed {
    logic          grant;
    logic          fault;
    logic [2:0]    rights;
    logic [LW-1:0] lpid;
    logic [PW-1:0] pid;
    logic [1:0]    exc;
    logic [CW-1:0] cause;
    logic [EA_W-1:0] faddr;
    logic [EA_W-1:0] dar;
    logic [CW-1:0] dsisr;
    logic [CW-1:0] err;
  } res_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [1:0] access_i = '0;
  logic [EA_W-1:0] ea_i = '0;
  logic hv_mode_i = 1'b0, problem_i = 1'b0;
  logic [LW-1:0] lpid_reg_i = 12'h5a3;
  logic [PW-1:0] pid_reg_i = 20'h1c0de;
  logic [2:0] amr_rights_i = 3'b111;
  logic [5:0] entry_i = '0;
  logic valid_o, grant_o, fault_o;
  logic [2:0] rights_o;
  logic [LW-1:0] lpid_o;
  logic [PW-1:0] pid_o;
  logic [1:0] exc_o;
  logic [CW-1:0] cause_o, dsisr_o, err_code_o;
  logic [EA_W-1:0] fault_addr_o, dar_o;

  always #4 clk_i = ~clk_i;

  xlate_auth_chk u0 (.*);

  int n_run = 0, n_fail = 0;
  res_t exp_q[$];
  string tag_q[$];
  logic [EA_W-1:0] m_dar = '0;
  logic [CW-1:0] m_dsisr = '0, m_err = '0;
  logic [EA_W-2-1:0] lo_cnt = 62'h123;

  function automatic res_t model(input logic [1:0] acc, input logic [EA_W-1:0] ea,
                                 input logic hv, input logic pr, input logic [5:0] ent,
                                 input logic [2:0] amr);
    res_t r;
    logic [1:0] q;
    logic legal;
    logic [2:0] rt;
    logic [2:0] need;
    r = '0;
    q = ea[EA_W-1:EA_W-2];
    legal = 1'b1;
    if (hv) begin
      r.lpid = (q == 2'd1 || q == 2'd2) ? lpid_reg_i : '0;
      r.pid  = (q == 2'd0 || q == 2'd1) ? pid_reg_i : '0;
    end else if (q == 2'd0 || q == 2'd3) begin
      r.lpid = lpid_reg_i;
      r.pid  = (q == 2'd0) ? pid_reg_i : '0;
    end else legal = 1'b0;
    if (ent[3] && pr) rt = 3'b000;
    else if (ent[3] ^ pr) rt = ent[2:0];
    else rt = ent[2:0] & amr;
    need = 3'b001 << acc;
    if (!legal) begin
      r.fault = 1'b1; r.lpid = '0; r.pid = '0;
      r.exc = (acc == 2'd2) ? 2'd0 : 2'd1;
      r.faddr = ea;
      m_err = '0;
      if (acc != 2'd2) m_dar = ea;
    end else if (acc == 2'd2 && ent[5:4] == 2'b11) begin
      r.fault = 1'b1; r.exc = 2'd2; r.cause = 8'h01; r.faddr = ea; m_err = 8'h01;
    end else if ((need & ~rt) != 0) begin
      r.fault = 1'b1; r.faddr = ea;
      r.cause = 8'h02 | ((acc == 2'd1) ? 8'h04 : 8'h00);
      if (acc == 2'd2) begin r.exc = 2'd2; m_err = r.cause; end
      else begin r.exc = 2'd3; m_dsisr = r.cause; m_dar = ea; m_err = '0; end
    end else begin
      r.grant = 1'b1; r.rights = rt;
    end
    r.dar = m_dar; r.dsisr = m_dsisr; r.err = m_err;
    return r;
  endfunction

  function automatic logic [5:0] ent(input logic [1:0] att, input logic priv, input logic [2:0] rt);
    return {att, priv, rt};
  endfunction

  task automatic drive(input string tag, input logic [1:0] acc, input logic [1:0] q,
                       input logic hv, input logic pr, input logic [5:0] e, input logic [2:0] amr);
    logic [EA_W-1:0] ea;
    lo_cnt = lo_cnt * 62'd7 + 62'h9e3;
    ea = {q, lo_cnt};
    access_i = acc; ea_i = ea; hv_mode_i = hv; problem_i = pr;
    entry_i = e; amr_rights_i = amr; req_valid_i = 1'b1;
    exp_q.push_back(model(acc, ea, hv, pr, e, amr));
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      res_t a, e;
      string t;
      a = '{grant_o, fault_o, rights_o, lpid_o, pid_o, exc_o, cause_o, fault_addr_o,
            dar_o, dsisr_o, err_code_o};
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected result act=%h exp=none", a);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s act g%0b f%0b rt%b l%h p%h x%0d c%h fa%h dar%h ds%h er%h exp g%0b f%0b rt%b l%h p%h x%0d c%h fa%h dar%h ds%h er%h",
            t, a.grant, a.fault, a.rights, a.lpid, a.pid, a.exc, a.cause, a.faddr, a.dar, a.dsisr, a.err,
            e.grant, e.fault, e.rights, e.lpid, e.pid, e.exc, e.cause, e.faddr, e.dar, e.dsisr, e.err);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    n_run++;
    if ({valid_o, grant_o, fault_o, rights_o, lpid_o, pid_o, exc_o, cause_o,
         fault_addr_o, dar_o, dsisr_o, err_code_o} !== '0) begin
      n_fail++;
      $display("FAIL R12 reset act=nonzero exp=0");
    end
    // R2 hypervisor quadrants
    for (int q = 0; q < 4; q++) drive("R2", 2'd0, q[1:0], 1'b1, 1'b0, ent(2'b00, 1'b0, 3'b111), 3'b111);
    // R3 guest legal quadrants
    drive("R3", 2'd0, 2'd0, 1'b0, 1'b0, ent(2'b00, 1'b0, 3'b001), 3'b111);
    drive("R3", 2'd1, 2'd3, 1'b0, 1'b1, ent(2'b00, 1'b0, 3'b010), 3'b000);
    // R4 guest illegal quadrants, entry would itself fault
    drive("R4", 2'd2, 2'd1, 1'b0, 1'b0, ent(2'b11, 1'b1, 3'b000), 3'b000);
    drive("R4", 2'd1, 2'd2, 1'b0, 1'b1, ent(2'b00, 1'b1, 3'b000), 3'b000);
    drive("R4", 2'd0, 2'd1, 1'b0, 1'b0, ent(2'b00, 1'b0, 3'b000), 3'b000);
    // R5 guarded fetch before permission checks
    drive("R5", 2'd2, 2'd3, 1'b1, 1'b0, ent(2'b11, 1'b0, 3'b111), 3'b111);
    drive("R5", 2'd2, 2'd0, 1'b0, 1'b1, ent(2'b11, 1'b1, 3'b000), 3'b000);
    drive("R5", 2'd0, 2'd0, 1'b1, 1'b0, ent(2'b11, 1'b0, 3'b001), 3'b111);
    // R6 privileged page in problem state
    drive("R6", 2'd0, 2'd0, 1'b0, 1'b1, ent(2'b00, 1'b1, 3'b111), 3'b111);
    drive("R6", 2'd1, 2'd0, 1'b0, 1'b1, ent(2'b00, 1'b1, 3'b111), 3'b111);
    // R7 mask ignored in problem state or on privileged page
    drive("R7", 2'd0, 2'd0, 1'b0, 1'b1, ent(2'b00, 1'b0, 3'b011), 3'b000);
    drive("R7", 2'd2, 2'd3, 1'b1, 1'b0, ent(2'b01, 1'b1, 3'b101), 3'b000);
    // R8 supervisor intersection with mask
    drive("R8", 2'd0, 2'd3, 1'b0, 1'b0, ent(2'b00, 1'b0, 3'b111), 3'b101);
    drive("R8", 2'd1, 2'd3, 1'b0, 1'b0, ent(2'b00, 1'b0, 3'b111), 3'b101);
    drive("R8", 2'd2, 2'd0, 1'b1, 1'b0, ent(2'b10, 1'b0, 3'b011), 3'b111);
    // R9 missing right on fetch, then R11 cleared by data fault, R10 segment keeps dsisr
    drive("R9", 2'd2, 2'd1, 1'b1, 1'b1, ent(2'b00, 1'b0, 3'b011), 3'b111);
    drive("R11", 2'd0, 2'd2, 1'b1, 1'b1, ent(2'b00, 1'b0, 3'b100), 3'b111);
    drive("R10", 2'd1, 2'd1, 1'b0, 1'b0, ent(2'b00, 1'b0, 3'b111), 3'b111);
    drive("R9", 2'd2, 2'd0, 1'b1, 1'b0, ent(2'b00, 1'b0, 3'b111), 3'b011);
    drive("R11", 2'd1, 2'd0, 1'b1, 1'b0, ent(2'b00, 1'b0, 3'b111), 3'b111);
    drive("R10", 2'd1, 2'd0, 1'b0, 1'b1, ent(2'b00, 1'b0, 3'b101), 3'b000);
    repeat (3) @(negedge clk_i);
    n_run++;
    if (exp_q.size() != 0 || valid_o) begin
      n_fail++;
      $display("FAIL R1 pending act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule